// File: doc/BRIEF.md
# PHY Link Bring-Up Sequencer

This block drives an Ethernet PHY into a known link mode by issuing a fixed series of register reads and writes through a management-bus master. It sits above that master and talks to it only through a request/done handshake. The master handles the serial framing and bit timing. The sequencer carries out one of four commands:

- a soft reset of the PHY;
- forcing 100 Mb/s full duplex;
- forcing 10 Mb/s half duplex;
- an auto-negotiation run that ends by reporting the best mode the link partner offers.

Waiting is counted in system-clock ticks by an internal interval timer. A retry counter bounds every polling loop, so no command can hang on a PHY that never answers as expected. When a command ends, a one-cycle done pulse comes out together with a 3-bit result code and an error flag. The code and the flag hold their values until the next command ends.

The result codes are: 0 success, 1 100 Mb/s full, 2 100 Mb/s half, 3 10 Mb/s full, 4 10 Mb/s half, 5 timeout, 6 no common mode. The command codes are: 0 reset, 1 force 100 full, 2 force 10 half, 3 auto-negotiate. The register addresses are: control 0, status 1, advertisement 4, partner ability 5, vendor page select 0x13 and vendor data 0x14.

Top module: `phy_linkup_seq`

## Requirements
- R1: A reset command (op 0) writes 0x8000 to register 0. It then reads register 0 repeatedly, and the first read that shows bit 15 clear ends the command with code 0 and the error flag low.
- R2: If reset polling has made RST_MAX_POLLS reads of register 0 and all of them showed bit 15 set, the command ends with code 5 and the error flag high.
- R3: Op 1 writes 0x2100 to register 0 and op 2 writes 0x0000 to register 0. Each of these is the only transaction of its command, and each ends with code 0.
- R4: Op 3 first writes 0x01E1 to register 4 and then writes 0x1200 to register 0, in that order.
- R5: Op 3 then reads register 1 until bit 5 is set. If AN_MAX_POLLS reads all show it not complete, the command ends with code 5, the error flag high, and no further transactions.
- R6: A status read of 0xFFFF counts as not complete, even though its bit 5 is set.
- R7: Once negotiation is complete, the vendor fix runs in this order: write 0x0006 to register 0x13, read register 0x14, write that value with bit 15 cleared back to 0x14, then write 0x0000 to 0x13.
- R8: The partner ability register (5) is read last and decoded by priority: bit 8 gives code 1, else bit 7 gives code 2, else bit 6 gives code 3, else bit 5 gives code 4.
- R9: If none of bits 8 to 5 of the partner ability value is set, the code is 6 and the error flag is high. The error flag is high exactly when the code is 5 or 6.
- R10: cmd_ready is high only while idle. A cmd_valid that arrives while busy is ignored. res_valid is a pulse one cycle long, and cmd_ready is high in the cycle it appears.
- R11: mgmt_req stays high, with mgmt_we, mgmt_addr and mgmt_wdata stable, from the time it rises until the cycle in which mgmt_done is seen.
- R12: After reset the block is idle. cmd_ready is 1, and mgmt_req, res_valid, res_code and res_err are all 0.
- R13: Between one poll step and the next register read, at least the configured poll interval in ticks elapses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 2 | Command code |
| cmd_ready | output | 1 | Idle and able to take a command |
| mgmt_req | output | 1 | Register access request to the management master |
| mgmt_we | output | 1 | 1 for a write, 0 for a read |
| mgmt_addr | output | 5 | PHY register address |
| mgmt_wdata | output | 16 | Write data |
| mgmt_done | input | 1 | One-cycle completion of the current access |
| mgmt_rdata | input | 16 | Read data, valid with mgmt_done |
| res_valid | output | 1 | One-cycle result pulse |
| res_code | output | 3 | Result code |
| res_err | output | 1 | Result is a timeout or no common mode |

## Verification
The checks assume the management master raises mgmt_done only while a request is pending and only for one cycle at a time, and that mgmt_rdata is valid in that cycle. The handshake-hold property depends on this. The bench's PHY model answers each request after a fixed latency, with a single done pulse. It never strobes done spontaneously, and it never answers the same request twice, because it ignores a request in the cycle right after its own done. Each command is issued only when cmd_ready is high, except in the one directed case that tests a command arriving while busy.

// File: rtl/linkup_pkg.sv
package linkup_pkg;

  typedef enum logic [1:0] {
    OP_RESET   = 2'd0,
    OP_F100FD  = 2'd1,
    OP_F10HD   = 2'd2,
    OP_AUTONEG = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    RC_OK      = 3'd0,
    RC_100FD   = 3'd1,
    RC_100HD   = 3'd2,
    RC_10FD    = 3'd3,
    RC_10HD    = 3'd4,
    RC_TIMEOUT = 3'd5,
    RC_NOMODE  = 3'd6
  } rc_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RST_WR, ST_RST_WAIT, ST_RST_RD, ST_F100, ST_F10,
    ST_AN_ADV, ST_AN_GO, ST_AN_WAIT, ST_AN_RD,
    ST_PG_SET, ST_VEND_RD, ST_VEND_WR, ST_PG_CLR, ST_LPA_RD
  } st_e;

  localparam logic [4:0] A_CTRL = 5'd0;
  localparam logic [4:0] A_STAT = 5'd1;
  localparam logic [4:0] A_ADV  = 5'd4;
  localparam logic [4:0] A_LPA  = 5'd5;
  localparam logic [4:0] A_PAGE = 5'h13;
  localparam logic [4:0] A_VEND = 5'h14;

  localparam logic [15:0] V_SOFTRST = 16'h8000;
  localparam logic [15:0] V_F100    = 16'h2100;
  localparam logic [15:0] V_F10     = 16'h0000;
  localparam logic [15:0] V_ADVERT  = 16'h01E1;
  localparam logic [15:0] V_ANSTART = 16'h1200;
  localparam logic [15:0] V_PAGE6   = 16'h0006;
  localparam logic [15:0] V_PAGE0   = 16'h0000;

endpackage

// File: rtl/linkup_timer.sv
module linkup_timer #(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TICK_W-1:0] ticks,
  output logic              expired
);
  logic [TICK_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? ticks : cnt_q - TICK_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0) && !load;

  // R13: the interval runs down one tick per cycle, never skipping
  p_tmr_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - TICK_W'(1)));
endmodule

// File: rtl/linkup_retry.sv
module linkup_retry #(
  parameter int RTY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [RTY_W-1:0] limit,
  output logic             last
);
  logic [RTY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr || inc;
    cnt_d  = clr ? '0 : cnt_q + RTY_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == limit - RTY_W'(1));

  // R2 / R5: a further poll is never scheduled once the limit is used up
  p_rty_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> (cnt_q < limit - RTY_W'(1)));
endmodule

// File: rtl/linkup_decode.sv
module linkup_decode
  import linkup_pkg::*;
(
  input  logic [3:0] ability,  // partner bits 8..5
  output logic [2:0] code
);
  always_comb begin
    if (ability[3])      code = RC_100FD;
    else if (ability[2]) code = RC_100HD;
    else if (ability[1]) code = RC_10FD;
    else if (ability[0]) code = RC_10HD;
    else                 code = RC_NOMODE;
  end
endmodule

// File: rtl/phy_linkup_seq.sv
module phy_linkup_seq
  import linkup_pkg::*;
#(
  parameter int RST_POLL_TICKS = 100000,
  parameter int AN_POLL_TICKS  = 5000000,
  parameter int RST_MAX_POLLS  = 500,
  parameter int AN_MAX_POLLS   = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  output logic        cmd_ready,
  output logic        mgmt_req,
  output logic        mgmt_we,
  output logic [4:0]  mgmt_addr,
  output logic [15:0] mgmt_wdata,
  input  logic        mgmt_done,
  input  logic [15:0] mgmt_rdata,
  output logic        res_valid,
  output logic [2:0]  res_code,
  output logic        res_err
);
  localparam int MAX_TICKS = (RST_POLL_TICKS > AN_POLL_TICKS) ? RST_POLL_TICKS : AN_POLL_TICKS;
  localparam int MAX_POLLS = (RST_MAX_POLLS > AN_MAX_POLLS) ? RST_MAX_POLLS : AN_MAX_POLLS;
  localparam int TICK_W    = $clog2(MAX_TICKS + 1);
  localparam int RTY_W     = $clog2(MAX_POLLS + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  st_e               st_q, st_d;
  logic [15:0]       vend_q, vend_d;
  logic              vend_en;
  logic              res_valid_q, res_err_q;
  logic [2:0]        res_code_q;
  logic              fin;
  logic [2:0]        fin_code;
  logic              tmr_load, tmr_exp;
  logic [TICK_W-1:0] tmr_ticks;
  logic              rty_clr, rty_inc, rty_last;
  logic [RTY_W-1:0]  rty_limit;
  logic [2:0]        dec_code;
  logic              an_phase;
  logic              stat_done_ok;

  linkup_timer #(.TICK_W(TICK_W)) u_tmr (
    .clk(clk), .rst_n(rst_ns), .load(tmr_load), .ticks(tmr_ticks), .expired(tmr_exp));

  linkup_retry #(.RTY_W(RTY_W)) u_rty (
    .clk(clk), .rst_n(rst_ns), .clr(rty_clr), .inc(rty_inc), .limit(rty_limit), .last(rty_last));

  linkup_decode u_dec (.ability(mgmt_rdata[8:5]), .code(dec_code));

  assign an_phase     = (st_q == ST_AN_GO) || (st_q == ST_AN_RD);
  assign tmr_ticks    = an_phase ? TICK_W'(AN_POLL_TICKS) : TICK_W'(RST_POLL_TICKS);
  assign rty_limit    = an_phase ? RTY_W'(AN_MAX_POLLS) : RTY_W'(RST_MAX_POLLS);
  assign stat_done_ok = (mgmt_rdata != 16'hFFFF) && mgmt_rdata[5];

  // management request decode from state
  always_comb begin
    mgmt_req   = 1'b1;
    mgmt_we    = 1'b1;
    mgmt_addr  = A_CTRL;
    mgmt_wdata = 16'h0000;
    unique case (st_q)
      ST_RST_WR:  mgmt_wdata = V_SOFTRST;
      ST_RST_RD:  mgmt_we = 1'b0;
      ST_F100:    mgmt_wdata = V_F100;
      ST_F10:     mgmt_wdata = V_F10;
      ST_AN_ADV:  begin mgmt_addr = A_ADV; mgmt_wdata = V_ADVERT; end
      ST_AN_GO:   mgmt_wdata = V_ANSTART;
      ST_AN_RD:   begin mgmt_we = 1'b0; mgmt_addr = A_STAT; end
      ST_PG_SET:  begin mgmt_addr = A_PAGE; mgmt_wdata = V_PAGE6; end
      ST_VEND_RD: begin mgmt_we = 1'b0; mgmt_addr = A_VEND; end
      ST_VEND_WR: begin mgmt_addr = A_VEND; mgmt_wdata = vend_q; end
      ST_PG_CLR:  begin mgmt_addr = A_PAGE; mgmt_wdata = V_PAGE0; end
      ST_LPA_RD:  begin mgmt_we = 1'b0; mgmt_addr = A_LPA; end
      default:    begin mgmt_req = 1'b0; mgmt_we = 1'b0; end
    endcase
  end

  // next state
  always_comb begin
    st_d     = st_q;
    vend_d   = mgmt_rdata & 16'h7FFF;
    vend_en  = 1'b0;
    tmr_load = 1'b0;
    rty_clr  = 1'b0;
    rty_inc  = 1'b0;
    fin      = 1'b0;
    fin_code = RC_OK;
    unique case (st_q)
      ST_IDLE: if (cmd_valid) begin
        rty_clr = 1'b1;
        unique case (op_e'(cmd_op))
          OP_RESET:  st_d = ST_RST_WR;
          OP_F100FD: st_d = ST_F100;
          OP_F10HD:  st_d = ST_F10;
          default:   st_d = ST_AN_ADV;
        endcase
      end
      ST_RST_WR: if (mgmt_done) begin st_d = ST_RST_WAIT; tmr_load = 1'b1; end
      ST_RST_WAIT: if (tmr_exp) st_d = ST_RST_RD;
      ST_RST_RD: if (mgmt_done) begin
        if (!mgmt_rdata[15]) begin
          fin = 1'b1; st_d = ST_IDLE;
        end else if (rty_last) begin
          fin = 1'b1; fin_code = RC_TIMEOUT; st_d = ST_IDLE;
        end else begin
          rty_inc = 1'b1; tmr_load = 1'b1; st_d = ST_RST_WAIT;
        end
      end
      ST_F100, ST_F10: if (mgmt_done) begin fin = 1'b1; st_d = ST_IDLE; end
      ST_AN_ADV: if (mgmt_done) st_d = ST_AN_GO;
      ST_AN_GO: if (mgmt_done) begin st_d = ST_AN_WAIT; tmr_load = 1'b1; end
      ST_AN_WAIT: if (tmr_exp) st_d = ST_AN_RD;
      ST_AN_RD: if (mgmt_done) begin
        if (stat_done_ok) begin
          st_d = ST_PG_SET;
        end else if (rty_last) begin
          fin = 1'b1; fin_code = RC_TIMEOUT; st_d = ST_IDLE;
        end else begin
          rty_inc = 1'b1; tmr_load = 1'b1; st_d = ST_AN_WAIT;
        end
      end
      ST_PG_SET:  if (mgmt_done) st_d = ST_VEND_RD;
      ST_VEND_RD: if (mgmt_done) begin vend_en = 1'b1; st_d = ST_VEND_WR; end
      ST_VEND_WR: if (mgmt_done) st_d = ST_PG_CLR;
      ST_PG_CLR:  if (mgmt_done) st_d = ST_LPA_RD;
      ST_LPA_RD: if (mgmt_done) begin
        fin = 1'b1; fin_code = dec_code; st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q        <= ST_IDLE;
      vend_q      <= 16'h0000;
      res_valid_q <= 1'b0;
      res_code_q  <= RC_OK;
      res_err_q   <= 1'b0;
    end else begin
      st_q        <= st_d;
      res_valid_q <= fin;
      if (vend_en) vend_q <= vend_d;
      if (fin) begin
        res_code_q <= fin_code;
        res_err_q  <= (fin_code == RC_TIMEOUT) || (fin_code == RC_NOMODE);
      end
    end
  end

  assign cmd_ready = (st_q == ST_IDLE);
  assign res_valid = res_valid_q;
  assign res_code  = res_code_q;
  assign res_err   = res_err_q;

  // R11: a pending access keeps its fields until the master answers
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_ns)
    (mgmt_req && !mgmt_done) |=>
      (mgmt_req && $stable(mgmt_we) && $stable(mgmt_addr) && $stable(mgmt_wdata)));

  // R10: a result is reported only once the block is idle again
  p_result_idle_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    res_valid |-> cmd_ready);

  // R10: the result strobe lasts a single cycle
  p_result_pulse_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    res_valid |=> !res_valid);

  // R9: the error flag agrees with the failure codes
  p_err_code_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    res_valid |-> (res_err == ((res_code == RC_TIMEOUT) || (res_code == RC_NOMODE))));

  // R7: the vendor write-back always has bit 15 cleared
  p_vend_bit15_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    (mgmt_req && mgmt_we && mgmt_addr == A_VEND) |-> !mgmt_wdata[15]);
endmodule

// File: tb/sim_phy_linkup_seq.sv
module sim_phy_linkup_seq;
  localparam int RP  = 20;
  localparam int AP  = 50;
  localparam int RL  = 4;
  localparam int AL  = 6;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic cmd_ready, mgmt_req, mgmt_we, res_valid, res_err;
  logic [4:0] mgmt_addr;
  logic [15:0] mgmt_wdata;
  logic mgmt_done = 1'b0;
  logic [15:0] mgmt_rdata = 16'h0000;
  logic [2:0] res_code;

  always #10 clk = ~clk;  // 50 MHz

  phy_linkup_seq #(.RST_POLL_TICKS(RP), .AN_POLL_TICKS(AP),
                   .RST_MAX_POLLS(RL), .AN_MAX_POLLS(AL)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ready(cmd_ready), .mgmt_req(mgmt_req), .mgmt_we(mgmt_we),
    .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata), .mgmt_done(mgmt_done),
    .mgmt_rdata(mgmt_rdata), .res_valid(res_valid), .res_code(res_code),
    .res_err(res_err));

  int total = 0, bad = 0;
  bit finished = 1'b0;

  // PHY model
  logic clr = 1'b0;
  int cfg_rb = 0, cfg_ab = 0;
  bit cfg_ff = 1'b0;
  logic [15:0] cfg_lpa = 16'h0000;
  logic [15:0] m_reg14;
  int rb_left, ab_left, lat, cyc = 0;
  int wr_n = 0, rd_ctrl_n = 0, rd_stat_n = 0, t_wdone = 0, t_rd1 = 0, hs_bad = 0;
  logic [4:0]  wr_a [0:15];
  logic [15:0] wr_d [0:15];
  logic p_req = 1'b0, p_done = 1'b0, p_we = 1'b0;
  logic [4:0] p_addr = 5'd0;
  logic [15:0] p_wdata = 16'd0;

  always @(posedge clk) begin
    cyc++;
    if (p_req && !p_done && rst_n &&
        (!mgmt_req || mgmt_addr != p_addr || mgmt_we != p_we || mgmt_wdata != p_wdata))
      hs_bad++;
    p_req = mgmt_req; p_we = mgmt_we; p_addr = mgmt_addr; p_wdata = mgmt_wdata;
    p_done = mgmt_done;
    mgmt_done <= 1'b0;
    if (clr) begin
      wr_n = 0; rd_ctrl_n = 0; rd_stat_n = 0; m_reg14 = 16'hC0A5;
      rb_left = cfg_rb; ab_left = cfg_ab; lat = 0; t_rd1 = 0; t_wdone = 0;
    end else if (mgmt_req && !mgmt_done) begin
      if (lat == LAT) begin
        lat = 0;
        mgmt_done <= 1'b1;
        if (mgmt_we) begin
          if (wr_n < 16) begin wr_a[wr_n] = mgmt_addr; wr_d[wr_n] = mgmt_wdata; end
          wr_n++;
          if (mgmt_addr == 5'h14) m_reg14 = mgmt_wdata;
          if (mgmt_addr == 5'h00 && mgmt_wdata == 16'h8000) t_wdone = cyc;
        end else begin
          case (mgmt_addr)
            5'h00: begin
              rd_ctrl_n++;
              if (rd_ctrl_n == 1) t_rd1 = cyc;
              if (rb_left > 0) begin rb_left--; mgmt_rdata <= 16'h8000; end
              else mgmt_rdata <= 16'h1000;
            end
            5'h01: begin
              rd_stat_n++;
              if (ab_left > 0) begin ab_left--; mgmt_rdata <= cfg_ff ? 16'hFFFF : 16'h7809; end
              else mgmt_rdata <= 16'h782D;
            end
            5'h05:   mgmt_rdata <= cfg_lpa;
            5'h14:   mgmt_rdata <= m_reg14;
            default: mgmt_rdata <= 16'h0000;
          endcase
        end
      end else lat++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] op, input int rb, input int ab, input bit ff,
                     input logic [15:0] lpa, output int code, output int err);
    int n;
    cfg_rb = rb; cfg_ab = ab; cfg_ff = ff; cfg_lpa = lpa;
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    cmd_op = op; cmd_valid = 1'b1; @(negedge clk); cmd_valid = 1'b0;
    n = 0;
    while (!res_valid && n < 5000) begin @(negedge clk); n++; end
    code = res_code; err = res_err;
    if (n >= 5000) check("R10 result", 0, 1);
    @(negedge clk);
    check("R10 pulse", res_valid, 0);
  endtask

  // {op, rb, ab, ff, lpa, expected code}
  localparam logic [29:0] VEC [0:12] = '{
    {2'd0, 4'd2, 4'd0, 1'b0, 16'h0000, 3'd0},
    {2'd0, 4'd9, 4'd0, 1'b0, 16'h0000, 3'd5},
    {2'd1, 4'd0, 4'd0, 1'b0, 16'h0000, 3'd0},
    {2'd2, 4'd0, 4'd0, 1'b0, 16'h0000, 3'd0},
    {2'd3, 4'd0, 4'd1, 1'b0, 16'h01E1, 3'd1},
    {2'd3, 4'd0, 4'd0, 1'b0, 16'h00E1, 3'd2},
    {2'd3, 4'd0, 4'd2, 1'b0, 16'h0061, 3'd3},
    {2'd3, 4'd0, 4'd0, 1'b0, 16'h0021, 3'd4},
    {2'd3, 4'd0, 4'd0, 1'b0, 16'h0001, 3'd6},
    {2'd3, 4'd0, 4'd9, 1'b0, 16'h01E1, 3'd5},
    {2'd3, 4'd0, 4'd3, 1'b1, 16'h0141, 3'd1},
    {2'd0, 4'd3, 4'd0, 1'b0, 16'h0000, 3'd0},
    {2'd3, 4'd0, 4'd5, 1'b0, 16'h00C0, 3'd2}
  };

  initial begin
    int code, err;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 ready", cmd_ready, 1);
    check("R12 req", mgmt_req, 0);
    check("R12 valid", res_valid, 0);
    check("R12 code", res_code, 0);
    check("R12 err", res_err, 0);

    for (int i = 0; i < 13; i++) begin
      logic [1:0] op; int rb, ab, ex; bit ff; logic [15:0] lpa;
      string tag;
      op = VEC[i][29:28]; rb = VEC[i][27:24]; ab = VEC[i][23:20];
      ff = VEC[i][19]; lpa = VEC[i][18:3]; ex = VEC[i][2:0];
      run(op, rb, ab, ff, lpa, code, err);
      if (op == 2'd0) tag = (ex == 5) ? "R2" : "R1";
      else if (op != 2'd3) tag = "R3";
      else if (ex == 5) tag = "R5";
      else if (ff) tag = "R6";
      else if (ex == 6) tag = "R9";
      else tag = "R8";
      check({tag, " code"}, code, ex);
      check("R9 err", err, (ex == 5 || ex == 6) ? 1 : 0);
      if (op == 2'd0) begin
        check("R1 writes", wr_n, 1);
        check("R1 wdata", wr_d[0], 16'h8000);
        check({tag, " polls"}, rd_ctrl_n, (rb + 1 < RL) ? rb + 1 : RL);
      end else if (op == 2'd1) begin
        check("R3 writes", wr_n, 1);
        check("R3 f100", {wr_a[0], wr_d[0]}, {5'd0, 16'h2100});
      end else if (op == 2'd2) begin
        check("R3 writes", wr_n, 1);
        check("R3 f10", {wr_a[0], wr_d[0]}, {5'd0, 16'h0000});
      end else begin
        check("R4 adv", {wr_a[0], wr_d[0]}, {5'd4, 16'h01E1});
        check("R4 start", {wr_a[1], wr_d[1]}, {5'd0, 16'h1200});
        check({(ff ? "R6" : "R5"), " polls"}, rd_stat_n, (ab + 1 < AL) ? ab + 1 : AL);
        if (ex == 5) check("R5 writes", wr_n, 2);
        else begin
          check("R7 writes", wr_n, 5);
          check("R7 page", {wr_a[2], wr_d[2]}, {5'h13, 16'h0006});
          check("R7 wb", {wr_a[3], wr_d[3]}, {5'h14, 16'h40A5});
          check("R7 page0", {wr_a[4], wr_d[4]}, {5'h13, 16'h0000});
        end
      end
    end

    // R13: poll interval after the reset write
    run(2'd0, 1, 0, 1'b0, 16'h0, code, err);
    check("R13 gap", (t_rd1 - t_wdone > RP) ? 1 : 0, 1);

    // R10: command while busy is ignored
    cfg_rb = 0; cfg_ab = 3; cfg_ff = 1'b0; cfg_lpa = 16'h0021;
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    cmd_op = 2'd3; cmd_valid = 1'b1; @(negedge clk); cmd_valid = 1'b0;
    repeat (5) @(negedge clk);
    check("R10 busy", cmd_ready, 0);
    cmd_op = 2'd1; cmd_valid = 1'b1; @(negedge clk); cmd_valid = 1'b0;
    begin
      int n = 0;
      while (!res_valid && n < 5000) begin @(negedge clk); n++; end
    end
    check("R10 ready", cmd_ready, 1);
    check("R10 code", res_code, 4);
    check("R10 writes", wr_n, 5);

    check("R11 handshake", hs_bad, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule